// File: doc/BRIEF.md
# AXI-Lite Request Bridge (Master Side)

This block lets simple user logic drive an AXI-Lite slave without handling any handshakes itself. A write is a single-cycle request strobe with an address and a data word. A read is a single-cycle request strobe with an address. Each request is placed in its own queue. A single engine then turns the queued requests into AXI-Lite transfers, one at a time. Every transfer moves exactly one data beat.

Write requests always take priority. A read is issued only once the write queue is empty and no write is still waiting for its response. A write and a read raised in the same cycle therefore reach the bus in that order, so the read sees the newly written value. The data returned by a read appears on the user side with a one-cycle valid strobe. The read response code comes with it. A one-cycle strobe with the response code marks the end of each write. The data width may be 32 or 64 bits. The protection fields are tied to zero and every byte strobe is held high.

Top module: `axil_req_bridge`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `m_awvalid`, `m_wvalid`, `m_arvalid`, `m_bready`, `m_rready`, `rd_valid_o` and `wr_done_o` all low, and both queues are emptied.
- R2: `m_awprot` and `m_arprot` are always 3'b000, and `m_wstrb` (one bit per data byte) is always all ones.
- R3: `m_awvalid` and `m_wvalid` rise in the same cycle. Each stays high, with `m_awaddr` or `m_wdata` unchanged, until the edge at which its own ready is seen high. It is low from the next cycle.
- R4: A write ends at the edge where `m_bvalid` and `m_bready` are both high. In the next cycle `wr_done_o` is high for exactly one cycle, and `wr_resp_o` carries the captured `m_bresp` (2'b00 = OKAY).
- R5: `m_arvalid` stays high with `m_araddr` stable until `m_arready` is seen. The data and response accepted on the `m_rvalid`/`m_rready` edge appear on `rd_data_o`/`rd_resp_o` in the next cycle, with `rd_valid_o` high for exactly one cycle.
- R6: Queued writes appear on the address channel in the order they were requested, one transfer at a time.
- R7: `m_arvalid` is never high while `m_awvalid`, `m_wvalid` or `m_bready` is high. A read requested in the same cycle as a write is issued only after that write's response has been accepted, so it returns the new data.
- R8: A write request made while the write queue (depth `WQ_DEPTH`) is full is discarded. With the slave stalled, `WQ_DEPTH+2` back-to-back writes result in exactly `WQ_DEPTH+1` bus writes, and the last request never reaches the slave.
- R9: Back-to-back read requests are returned on `rd_valid_o` in request order, each with the data stored at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_req_i | input | 1 | One-cycle write request strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_req_i | input | 1 | One-cycle read request strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Returned read data |
| rd_resp_o | output | 2 | Returned read response |
| rd_valid_o | output | 1 | One-cycle strobe qualifying read data |
| wr_done_o | output | 1 | One-cycle strobe at the end of each write |
| wr_resp_o | output | 2 | Write response of the finished write |
| m_awaddr | output | ADDR_W | Write address channel address |
| m_awprot | output | 3 | Write protection, constant zero |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data channel data |
| m_wstrb | output | DATA_W/8 | Byte strobes, all ones |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arprot | output | 3 | Read protection, constant zero |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
Suppose a queue pointer slips or a pop is lost. The address sequence on the write channel then departs from the request order at the first affected transfer. Later, a read returns data from a write that never landed. Suppose the engine state is corrupted so that a read starts while a write is open. Then `m_arvalid` overlaps `m_bready` within one cycle. The same-cycle write-then-read test also returns stale data. Suppose the full flag is computed wrongly. Then the overflow test sees one bus write too many or too few once the stalled slave is released.

// File: rtl/axrb_pkg.sv
package axrb_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_WRITE = 2'd1,
    ENG_READ  = 2'd2
  } eng_state_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axrb_fifo.sv
module axrb_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW:0]      wr_ptr;
  logic [PW:0]      rd_ptr;
  logic             full;
  logic             do_push;
  logic             do_pop;

  assign empty    = (wr_ptr == rd_ptr);
  assign full     = (wr_ptr[PW] != rd_ptr[PW]) && (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign pop_data = mem[rd_ptr[PW-1:0]];

  // storage has no reset so it can map onto RAM resources
  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_ptr[PW-1:0]] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/axrb_engine.sv
module axrb_engine
  import axrb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wq_empty,
  input  logic [ADDR_W-1:0] wq_addr,
  input  logic [DATA_W-1:0] wq_data,
  output logic              wq_pop,
  input  logic              rq_empty,
  input  logic [ADDR_W-1:0] rq_addr,
  output logic              rq_pop,
  output logic [ADDR_W-1:0] awaddr,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic [ADDR_W-1:0] araddr,
  output logic              arvalid,
  input  logic              arready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rvalid,
  output logic              rready,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_resp,
  output logic              rd_valid,
  output logic              wr_done,
  output logic [1:0]        wr_resp
);
  eng_state_t state;

  // writes win; a read leaves only once the write side is drained
  assign wq_pop = (state == ENG_IDLE) && !wq_empty;
  assign rq_pop = (state == ENG_IDLE) && wq_empty && !rq_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      awaddr   <= '0;
      awvalid  <= 1'b0;
      wdata    <= '0;
      wvalid   <= 1'b0;
      bready   <= 1'b0;
      araddr   <= '0;
      arvalid  <= 1'b0;
      rready   <= 1'b0;
      rd_data  <= '0;
      rd_resp  <= RESP_OKAY;
      rd_valid <= 1'b0;
      wr_done  <= 1'b0;
      wr_resp  <= RESP_OKAY;
    end else begin
      rd_valid <= 1'b0;
      wr_done  <= 1'b0;
      unique case (state)
        ENG_IDLE: begin
          if (wq_pop) begin
            awaddr  <= wq_addr;
            wdata   <= wq_data;
            awvalid <= 1'b1;
            wvalid  <= 1'b1;
            bready  <= 1'b1;
            state   <= ENG_WRITE;
          end else if (rq_pop) begin
            araddr  <= rq_addr;
            arvalid <= 1'b1;
            rready  <= 1'b1;
            state   <= ENG_READ;
          end
        end
        ENG_WRITE: begin
          if (awready) awvalid <= 1'b0;
          if (wready)  wvalid  <= 1'b0;
          if (bvalid) begin
            bready  <= 1'b0;
            wr_done <= 1'b1;
            wr_resp <= bresp;
            state   <= ENG_IDLE;
          end
        end
        ENG_READ: begin
          if (arready) arvalid <= 1'b0;
          if (rvalid) begin
            rready   <= 1'b0;
            rd_valid <= 1'b1;
            rd_data  <= rdata;
            rd_resp  <= rresp;
            state    <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/axil_req_bridge.sv
module axil_req_bridge #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WQ_DEPTH = 8,
  parameter int RQ_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_req_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                rd_req_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [1:0]          rd_resp_o,
  output logic                rd_valid_o,
  output logic                wr_done_o,
  output logic [1:0]          wr_resp_o,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [2:0]          m_awprot,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [2:0]          m_arprot,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rvalid,
  output logic                m_rready
);
  localparam int STRB_W = DATA_W / 8;
  localparam int WQ_W   = ADDR_W + DATA_W;

  if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
    $error("axil_req_bridge: DATA_W must be 32 or 64");
  end

  logic [WQ_W-1:0]   wq_out;
  logic              wq_empty;
  logic              wq_pop;
  logic [ADDR_W-1:0] rq_out;
  logic              rq_empty;
  logic              rq_pop;

  assign m_awprot = 3'b000;
  assign m_arprot = 3'b000;
  assign m_wstrb  = {STRB_W{1'b1}};

  axrb_fifo #(.WIDTH(WQ_W), .DEPTH(WQ_DEPTH)) u_wq (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_req_i),
    .push_data ({wr_addr_i, wr_data_i}),
    .pop       (wq_pop),
    .pop_data  (wq_out),
    .empty     (wq_empty)
  );

  axrb_fifo #(.WIDTH(ADDR_W), .DEPTH(RQ_DEPTH)) u_rq (
    .clk       (clk),
    .rst       (rst),
    .push      (rd_req_i),
    .push_data (rd_addr_i),
    .pop       (rq_pop),
    .pop_data  (rq_out),
    .empty     (rq_empty)
  );

  axrb_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .wq_empty (wq_empty),
    .wq_addr  (wq_out[WQ_W-1:DATA_W]),
    .wq_data  (wq_out[DATA_W-1:0]),
    .wq_pop   (wq_pop),
    .rq_empty (rq_empty),
    .rq_addr  (rq_out),
    .rq_pop   (rq_pop),
    .awaddr   (m_awaddr),
    .awvalid  (m_awvalid),
    .awready  (m_awready),
    .wdata    (m_wdata),
    .wvalid   (m_wvalid),
    .wready   (m_wready),
    .bresp    (m_bresp),
    .bvalid   (m_bvalid),
    .bready   (m_bready),
    .araddr   (m_araddr),
    .arvalid  (m_arvalid),
    .arready  (m_arready),
    .rdata    (m_rdata),
    .rresp    (m_rresp),
    .rvalid   (m_rvalid),
    .rready   (m_rready),
    .rd_data  (rd_data_o),
    .rd_resp  (rd_resp_o),
    .rd_valid (rd_valid_o),
    .wr_done  (wr_done_o),
    .wr_resp  (wr_resp_o)
  );

endmodule

// File: rtl/axrb_checker.sv
module axrb_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   awaddr,
  input logic [2:0]          awprot,
  input logic                awvalid,
  input logic                awready,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W/8-1:0] wstrb,
  input logic                wvalid,
  input logic                wready,
  input logic                bvalid,
  input logic                bready,
  input logic [ADDR_W-1:0]   araddr,
  input logic [2:0]          arprot,
  input logic                arvalid,
  input logic                arready,
  input logic                rvalid,
  input logic                rready,
  input logic                rd_valid,
  input logic                wr_done
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!awvalid && !wvalid && !arvalid && !bready && !rready && !rd_valid && !wr_done));

  a_r2_const_fields: assert property (@(posedge clk) disable iff (rst)
    (awprot == 3'b000) && (arprot == 3'b000) && (&wstrb));

  a_r3_aw_hold: assert property (@(posedge clk) disable iff (rst)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr)));

  a_r3_w_hold: assert property (@(posedge clk) disable iff (rst)
    (wvalid && !wready) |=> (wvalid && $stable(wdata)));

  a_r3_aw_w_together: assert property (@(posedge clk) disable iff (rst)
    $rose(awvalid) |-> $rose(wvalid));

  a_r4_done_after_b: assert property (@(posedge clk) disable iff (rst)
    (bvalid && bready) |=> wr_done);

  a_r5_ar_hold: assert property (@(posedge clk) disable iff (rst)
    (arvalid && !arready) |=> (arvalid && $stable(araddr)));

  a_r5_rd_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r7_one_at_a_time: assert property (@(posedge clk) disable iff (rst)
    arvalid |-> (!awvalid && !wvalid && !bready));

endmodule

bind axil_req_bridge axrb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_axrb_chk (
  .clk      (clk),
  .rst      (rst),
  .awaddr   (m_awaddr),
  .awprot   (m_awprot),
  .awvalid  (m_awvalid),
  .awready  (m_awready),
  .wdata    (m_wdata),
  .wstrb    (m_wstrb),
  .wvalid   (m_wvalid),
  .wready   (m_wready),
  .bvalid   (m_bvalid),
  .bready   (m_bready),
  .araddr   (m_araddr),
  .arprot   (m_arprot),
  .arvalid  (m_arvalid),
  .arready  (m_arready),
  .rvalid   (m_rvalid),
  .rready   (m_rready),
  .rd_valid (rd_valid_o),
  .wr_done  (wr_done_o)
);

// File: tb/axil_req_bridge_bench.sv
`timescale 1ns / 1ps
module axil_req_bridge_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int WQD = 8;
  localparam int RQD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          wr_req_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic          rd_req_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [1:0]    rd_resp_o;
  logic          rd_valid_o, wr_done_o;
  logic [1:0]    wr_resp_o;
  logic [AW-1:0] m_awaddr, m_araddr;
  logic [2:0]    m_awprot, m_arprot;
  logic          m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
  logic [DW-1:0] m_wdata;
  logic [DW/8-1:0] m_wstrb;
  logic          m_awready, m_wready, m_bvalid, m_arready, m_rvalid;
  logic [1:0]    m_bresp, m_rresp;
  logic [DW-1:0] m_rdata;

  axil_req_bridge #(.ADDR_W(AW), .DATA_W(DW), .WQ_DEPTH(WQD), .RQ_DEPTH(RQD)) u_axil_req_bridge (
    .clk(clk), .rst(rst),
    .wr_req_i(wr_req_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_req_i(rd_req_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .rd_resp_o(rd_resp_o), .rd_valid_o(rd_valid_o),
    .wr_done_o(wr_done_o), .wr_resp_o(wr_resp_o),
    .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  // ---------------- slave model ----------------
  logic          hold = 1'b0;   // withhold every ready
  logic          w_lag = 1'b0;  // accept data only after address
  logic [DW-1:0] mem [32];
  logic          aw_got, w_got, ar_got;
  logic [AW-1:0] aw_q, ar_q;
  logic [DW-1:0] w_q;

  always @(posedge clk) begin
    if (rst) begin
      m_awready <= 1'b0; m_wready <= 1'b0; m_arready <= 1'b0;
      m_bvalid <= 1'b0; m_rvalid <= 1'b0; m_bresp <= 2'b00; m_rresp <= 2'b00;
      m_rdata <= '0; aw_got <= 1'b0; w_got <= 1'b0; ar_got <= 1'b0;
      aw_q <= '0; ar_q <= '0; w_q <= '0;
      for (int i = 0; i < 32; i++) mem[i] <= '0;
    end else begin
      m_awready <= 1'b0; m_wready <= 1'b0; m_arready <= 1'b0;
      if (!hold && m_awvalid && !m_awready && !aw_got) m_awready <= 1'b1;
      if (m_awvalid && m_awready) begin aw_got <= 1'b1; aw_q <= m_awaddr; end
      if (!hold && m_wvalid && !m_wready && !w_got && (!w_lag || aw_got)) m_wready <= 1'b1;
      if (m_wvalid && m_wready) begin w_got <= 1'b1; w_q <= m_wdata; end
      if (aw_got && w_got && !m_bvalid) begin
        mem[aw_q[6:2]] <= w_q;
        m_bvalid <= 1'b1;
        m_bresp  <= (aw_q == 32'h7C) ? 2'b10 : 2'b00;
        aw_got <= 1'b0; w_got <= 1'b0;
      end
      if (m_bvalid && m_bready) m_bvalid <= 1'b0;
      if (!hold && m_arvalid && !m_arready && !ar_got) m_arready <= 1'b1;
      if (m_arvalid && m_arready) begin ar_got <= 1'b1; ar_q <= m_araddr; end
      if (ar_got && !m_rvalid) begin
        m_rvalid <= 1'b1;
        m_rdata  <= mem[ar_q[6:2]];
        m_rresp  <= (ar_q == 32'h7C) ? 2'b10 : 2'b00;
        ar_got <= 1'b0;
      end
      if (m_rvalid && m_rready) m_rvalid <= 1'b0;
    end
  end

  // ---------------- monitors (sampled mid-cycle) ----------------
  int cyc = 0;
  int aw_cnt = 0, done_cnt = 0, rd_cnt = 0;
  int last_b_cyc = 0, last_ar_cyc = 0;
  logic [AW-1:0] aw_log [64];
  logic [DW-1:0] rd_log [64];
  logic [1:0]    rresp_log [64];
  logic [1:0]    last_wresp = 2'b00;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (m_awvalid && m_awready) begin
        if (aw_cnt < 64) aw_log[aw_cnt] = m_awaddr;
        aw_cnt = aw_cnt + 1;
      end
      if (m_bvalid && m_bready) last_b_cyc = cyc;
      if (m_arvalid && m_arready) last_ar_cyc = cyc;
      if (wr_done_o) begin done_cnt = done_cnt + 1; last_wresp = wr_resp_o; end
      if (rd_valid_o) begin
        if (rd_cnt < 64) begin rd_log[rd_cnt] = rd_data_o; rresp_log[rd_cnt] = rd_resp_o; end
        rd_cnt = rd_cnt + 1;
      end
    end
  end

  // ---------------- checking helpers ----------------
  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_req_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_req_i = 1'b0;
  endtask

  task automatic push_rd(input logic [AW-1:0] a);
    @(negedge clk);
    rd_req_i = 1'b1; rd_addr_i = a;
    @(negedge clk);
    rd_req_i = 1'b0;
  endtask

  task automatic wait_done(input int target);
    for (int i = 0; i < 2000 && done_cnt < target; i++) @(negedge clk);
  endtask

  task automatic wait_rd(input int target);
    for (int i = 0; i < 2000 && rd_cnt < target; i++) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    @(negedge clk);
    chk(!m_awvalid && !m_wvalid && !m_arvalid, "R1 valids low in reset", {m_awvalid, m_wvalid, m_arvalid}, 0);
    chk(!m_bready && !m_rready && !rd_valid_o && !wr_done_o, "R1 readies/strobes low in reset",
        {m_bready, m_rready, rd_valid_o, wr_done_o}, 0);
    chk(m_awprot == 3'b000 && m_arprot == 3'b000, "R2 prot zero", {m_awprot, m_arprot}, 0);
    chk(m_wstrb == 4'hF, "R2 wstrb all ones", m_wstrb, 4'hF);
  endtask

  task automatic t_single;
    int d0;
    d0 = done_cnt;
    push_wr(32'h10, 32'h1111_2222);
    wait_done(d0 + 1);
    chk(done_cnt == d0 + 1, "R4 write completes once", done_cnt, d0 + 1);
    chk(last_wresp == 2'b00, "R4 okay response", last_wresp, 0);
    chk(mem[4] == 32'h1111_2222, "R4 slave got data", mem[4], 32'h1111_2222);
    push_rd(32'h10);
    wait_rd(rd_cnt + 1);
    chk(rd_log[rd_cnt-1] == 32'h1111_2222, "R5 read data", rd_log[rd_cnt-1], 32'h1111_2222);
    chk(rresp_log[rd_cnt-1] == 2'b00, "R5 read resp okay", rresp_log[rd_cnt-1], 0);
  endtask

  task automatic t_hold;
    int d0;
    bit held;
    d0 = done_cnt;
    held = 1'b1;
    hold = 1'b1;
    push_wr(32'h20, 32'hCAFE_0020);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!(m_awvalid && m_wvalid && m_awaddr == 32'h20 && m_wdata == 32'hCAFE_0020)) held = 1'b0;
      @(negedge clk);
    end
    chk(held, "R3 aw/w held with stable payload while stalled", held, 1);
    hold = 1'b0;
    wait_done(d0 + 1);
    @(negedge clk);
    chk(!m_awvalid && !m_wvalid, "R3 valids drop after handshake", {m_awvalid, m_wvalid}, 0);
    chk(mem[8] == 32'hCAFE_0020, "R3 stalled write landed", mem[8], 32'hCAFE_0020);
  endtask

  task automatic t_order;
    int a0, d0;
    bit ok;
    a0 = aw_cnt; d0 = done_cnt; ok = 1'b1;
    w_lag = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      wr_req_i = 1'b1; wr_addr_i = 32'h40 + 4 * i; wr_data_i = 32'hB000 + i;
      @(negedge clk);
    end
    wr_req_i = 1'b0;
    wait_done(d0 + 5);
    w_lag = 1'b0;
    for (int i = 0; i < 5; i++) if (aw_log[a0+i] != 32'h40 + 4 * i) ok = 1'b0;
    chk(ok, "R6 address order", aw_log[a0], 32'h40);
    chk(mem[20] == 32'hB004, "R6 last burst word", mem[20], 32'hB004);
  endtask

  task automatic t_error;
    int d0;
    d0 = done_cnt;
    push_wr(32'h7C, 32'hDEAD_BEEF);
    wait_done(d0 + 1);
    chk(last_wresp == 2'b10, "R4 error response passed up", last_wresp, 2'b10);
    push_rd(32'h7C);
    wait_rd(rd_cnt + 1);
    chk(rresp_log[rd_cnt-1] == 2'b10, "R5 read error resp", rresp_log[rd_cnt-1], 2'b10);
    chk(rd_log[rd_cnt-1] == 32'hDEAD_BEEF, "R5 read data with error", rd_log[rd_cnt-1], 32'hDEAD_BEEF);
  endtask

  task automatic t_same_cycle;
    int r0;
    r0 = rd_cnt;
    @(negedge clk);
    wr_req_i = 1'b1; wr_addr_i = 32'h04; wr_data_i = 32'h0000_0063;
    rd_req_i = 1'b1; rd_addr_i = 32'h04;
    @(negedge clk);
    wr_req_i = 1'b0; rd_req_i = 1'b0;
    wait_rd(r0 + 1);
    chk(rd_log[r0] == 32'h63, "R7 read sees same-cycle write", rd_log[r0], 32'h63);
    chk(last_ar_cyc > last_b_cyc, "R7 read address after write response", last_ar_cyc, last_b_cyc + 1);
  endtask

  task automatic t_reads;
    int r0;
    r0 = rd_cnt;
    @(negedge clk);
    rd_req_i = 1'b1; rd_addr_i = 32'h10; @(negedge clk);
    rd_addr_i = 32'h7C; @(negedge clk);
    rd_addr_i = 32'h20; @(negedge clk);
    rd_req_i = 1'b0;
    wait_rd(r0 + 3);
    chk(rd_log[r0]   == 32'h1111_2222, "R9 first read", rd_log[r0], 32'h1111_2222);
    chk(rd_log[r0+1] == 32'hDEAD_BEEF, "R9 second read", rd_log[r0+1], 32'hDEAD_BEEF);
    chk(rd_log[r0+2] == 32'hCAFE_0020, "R9 third read", rd_log[r0+2], 32'hCAFE_0020);
  endtask

  task automatic t_overflow;
    int a0, d0;
    a0 = aw_cnt; d0 = done_cnt;
    hold = 1'b1;
    @(negedge clk);
    for (int i = 0; i < WQD + 2; i++) begin
      wr_req_i = 1'b1; wr_addr_i = 32'h80 + 4 * i; wr_data_i = 32'hA000 + i;
      @(negedge clk);
    end
    wr_req_i = 1'b0;
    repeat (4) @(negedge clk);
    hold = 1'b0;
    wait_done(d0 + WQD + 1);
    repeat (30) @(negedge clk);
    chk(aw_cnt - a0 == WQD + 1, "R8 accepted writes", aw_cnt - a0, WQD + 1);
    chk(mem[(32'h80 + 4 * WQD) >> 2 & 31] == 32'hA000 + WQD, "R8 last kept write",
        mem[(32'h80 + 4 * WQD) >> 2 & 31], 32'hA000 + WQD);
    chk(mem[(32'h80 + 4 * (WQD + 1)) >> 2 & 31] == 32'h0, "R8 dropped write absent",
        mem[(32'h80 + 4 * (WQD + 1)) >> 2 & 31], 0);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_single();
    t_hold();
    t_order();
    t_error();
    t_same_cycle();
    t_reads();
    t_overflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule